// File: doc/BRIEF.md
# Function-Coded Arithmetic and Logic Unit with Flag Register

This block is an 8-bit arithmetic and logic unit. It takes two operands, B and C, and a 3-bit function code that selects one operation. The operations are addition, increment, bitwise AND, OR and XOR, complement, and a circular rotate-left. Increment, complement and rotate read only the B operand. The result is combinational. It appears on a shared data-bus output only while the bus enable input is high. When the enable is low, the bus word is held at zero and its valid bit is low, so an OR-combined bus is not disturbed.

Carry, zero and sign flags are derived from the selected operation and its result. They are captured into a 3-bit condition-code register only on a clock edge where the load strobe is high. A control sequencer can therefore drive the bus in one step and latch the flags in another.

Top module: `fcode_alu`

## Requirements
- R1: Function code 000 adds B and C with carry-in 0. The result is the low 8 bits of the sum, and carry is the carry out of bit 7.
- R2: Function code 001 produces B+1 (mod 256). Carry is 1 exactly when B is 0xFF.
- R3: Function codes 010, 011 and 100 produce B AND C, B OR C and B XOR C respectively.
- R4: Function code 101 produces the bitwise complement of B. C has no effect on this result.
- R5: Function code 110 rotates B left by one place. Result bit 0 is B bit 7, and result bit i is B bit i-1 for i from 1 to 7.
- R6: Function code 111 produces 0x00. Its flags are computed from that zero result, so zero is 1 and sign is 0.
- R7: For every function code other than 000 and 001, the carry flag is 0.
- R8: The zero flag is 1 exactly when all result bits are 0. The sign flag equals result bit 7.
- R9: While bus_en is high, bus_data carries the result and bus_valid is 1. While bus_en is low, bus_data is 0x00 and bus_valid is 0.
- R10: On a rising clock edge with load_cc high, the flag outputs take the carry, zero and sign of the current operation. With load_cc low, they keep their values.
- R11: While rst_n is low, all three flag outputs are 0, whatever load_cc is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the condition-code register |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_b | input | 8 | Operand B, the source for all single-operand operations |
| opnd_c | input | 8 | Operand C |
| func | input | 3 | Function code |
| bus_en | input | 1 | Drives the result onto the bus output when high |
| load_cc | input | 1 | Captures the flags on the next rising edge when high |
| bus_data | output | 8 | Gated result word |
| bus_valid | output | 1 | High while the result is being driven |
| cc_carry | output | 1 | Registered carry flag |
| cc_zero | output | 1 | Registered zero flag |
| cc_sign | output | 1 | Registered sign flag |

## Verification
The bench builds the block with its default width of 8. At that width the carry-out of 0xFF+0x01 and of 0x80+0x80, the increment of 0xFF, and the wrap of bit 7 into bit 0 by the rotate can all be set up directly. Random operands and function codes, including the reserved code, are mixed with random enable and load strobes. This exercises flag hold across many cycles and shows that the bus stays at zero whenever the enable is low.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        FN_ADD = 3'b000,
        FN_INC = 3'b001,
        FN_AND = 3'b010,
        FN_OR  = 3'b011,
        FN_XOR = 3'b100,
        FN_NOT = 3'b101,
        FN_ROL = 3'b110,
        FN_RSV = 3'b111
    } alu_fn_e;

    typedef struct packed {
        logic carry;
        logic zero;
        logic sign;
    } cc_t;

    typedef struct packed {
        cc_t cc;
    } alu_state_t;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        assign sum[i]     = a_in[i] ^ b_in[i] ^ chain[i];
        assign chain[i+1] = (a_in[i] & b_in[i]) | (chain[i] & (a_in[i] ^ b_in[i]));
    end

    assign cout = chain[WIDTH];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] b_in,
    input  logic [WIDTH-1:0] c_in,
    input  alu_fn_e          fsel,
    output logic [WIDTH-1:0] res
);
    logic [WIDTH-1:0] rotated;

    assign rotated[0] = b_in[WIDTH-1];
    for (genvar i = 1; i < WIDTH; i++) begin : g_rot
        assign rotated[i] = b_in[i-1];
    end

    always_comb begin
        res = '0;
        unique case (fsel)
            FN_AND:  res = b_in & c_in;
            FN_OR:   res = b_in | c_in;
            FN_XOR:  res = b_in ^ c_in;
            FN_NOT:  res = ~b_in;
            FN_ROL:  res = rotated;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] res,
    input  logic             carry_in,
    output cc_t              flags
);
    always_comb begin
        flags.carry = carry_in;
        flags.zero  = ~|res;
        flags.sign  = res[WIDTH-1];
    end
endmodule

// File: rtl/fcode_alu.sv
module fcode_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [WIDTH-1:0] opnd_c,
    input  logic [2:0]       func,
    input  logic             bus_en,
    input  logic             load_cc,
    output logic [WIDTH-1:0] bus_data,
    output logic             bus_valid,
    output logic             cc_carry,
    output logic             cc_zero,
    output logic             cc_sign
);
    alu_fn_e          fsel;
    logic             is_arith;
    logic [WIDTH-1:0] add_rhs;
    logic             add_cin;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;
    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] result;
    logic             carry_raw;
    cc_t              flags_now;
    alu_state_t       state_d;
    alu_state_t       state_q;

    assign fsel = alu_fn_e'(func);

    always_comb begin
        is_arith = (fsel == FN_ADD) || (fsel == FN_INC);
        add_rhs  = (fsel == FN_INC) ? '0 : opnd_c;
        add_cin  = (fsel == FN_INC);
    end

    alu_adder #(.WIDTH(WIDTH)) u_add (
        .a_in (opnd_b),
        .b_in (add_rhs),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout)
    );

    alu_logic #(.WIDTH(WIDTH)) u_log (
        .b_in (opnd_b),
        .c_in (opnd_c),
        .fsel (fsel),
        .res  (logic_res)
    );

    always_comb begin
        result    = is_arith ? add_sum : logic_res;
        carry_raw = is_arith & add_cout;
    end

    alu_flags #(.WIDTH(WIDTH)) u_flg (
        .res      (result),
        .carry_in (carry_raw),
        .flags    (flags_now)
    );

    always_comb begin
        state_d = state_q;
        if (load_cc) begin
            state_d.cc = flags_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        bus_data  = bus_en ? result : '0;
        bus_valid = bus_en;
        cc_carry  = state_q.cc.carry;
        cc_zero   = state_q.cc.zero;
        cc_sign   = state_q.cc.sign;
    end

    AST_BUS_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> (bus_data == '0) && !bus_valid); // R9

    AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_cc |=> $stable({cc_carry, cc_zero, cc_sign})); // R10

    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        load_cc && (func[2] || func[1]) |=> !cc_carry); // R7

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 3'b111) && bus_en |-> (bus_data == '0)); // R6

    AST_ZERO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        load_cc && bus_en |=> cc_zero == ($past(bus_data) == '0)); // R8

    AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        load_cc && (func == 3'b001) && (&opnd_b) |=> cc_carry && cc_zero); // R2
endmodule

// File: tb/sim_fcode_alu.sv
module sim_fcode_alu;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opnd_b = '0;
    logic [7:0] opnd_c = '0;
    logic [2:0] func = '0;
    logic       bus_en = 1'b0;
    logic       load_cc = 1'b0;
    logic [7:0] bus_data;
    logic       bus_valid;
    logic       cc_carry;
    logic       cc_zero;
    logic       cc_sign;

    int n_chk = 0;
    int n_fail = 0;
    logic [2:0] exp_cc = 3'b000;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcode_alu #(.WIDTH(8)) u0 (
        .clk(clk), .rst_n(rst_n), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .func(func), .bus_en(bus_en), .load_cc(load_cc),
        .bus_data(bus_data), .bus_valid(bus_valid),
        .cc_carry(cc_carry), .cc_zero(cc_zero), .cc_sign(cc_sign)
    );

    // returns {carry, result}
    function automatic logic [8:0] model(input logic [7:0] b, input logic [7:0] c,
                                         input logic [2:0] f);
        logic [8:0] wide;
        case (f)
            3'd0: wide = {1'b0, b} + {1'b0, c};
            3'd1: wide = {1'b0, b} + 9'd1;
            3'd2: wide = {1'b0, b & c};
            3'd3: wide = {1'b0, b | c};
            3'd4: wide = {1'b0, b ^ c};
            3'd5: wide = {1'b0, ~b};
            3'd6: wide = {1'b0, b[6:0], b[7]};
            default: wide = 9'd0;
        endcase
        return wide;
    endfunction

    function automatic string op_tag(input logic [2:0] f);
        case (f)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2, 3'd3, 3'd4: return "R3";
            3'd5: return "R4";
            3'd6: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [7:0] b, input logic [7:0] c, input logic [2:0] f,
                         input logic en, input logic ld);
        logic [8:0] m;
        @(negedge clk);
        opnd_b = b; opnd_c = c; func = f; bus_en = en; load_cc = ld;
        #1;
        m = model(b, c, f);
        if (en) check(op_tag(f), {8'h0, bus_data}, {8'h0, m[7:0]});
        else    check("R9", {8'h0, bus_data}, 16'h0);
        check("R9", {15'h0, bus_valid}, {15'h0, en});
        if (ld) exp_cc = {m[8], (m[7:0] == 8'h00), m[7]};
        @(posedge clk);
        #1;
        if (!ld)             check("R10", {13'h0, cc_carry, cc_zero, cc_sign}, {13'h0, exp_cc});
        else if (f >= 3'd2)  check("R7 R8", {13'h0, cc_carry, cc_zero, cc_sign}, {13'h0, exp_cc});
        else                 check(op_tag(f), {13'h0, cc_carry, cc_zero, cc_sign}, {13'h0, exp_cc});
        load_cc = 1'b0;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0A1C);
        load_cc = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R11", {13'h0, cc_carry, cc_zero, cc_sign}, 16'h0);
        @(negedge clk);
        load_cc = 1'b0;
        rst_n = 1'b1;
        #1;
        check("R11", {13'h0, cc_carry, cc_zero, cc_sign}, 16'h0);

        do_op(8'hFF, 8'h01, 3'd0, 1'b1, 1'b1);   // R1 carry + zero
        do_op(8'h80, 8'h80, 3'd0, 1'b1, 1'b1);   // R1
        do_op(8'h3C, 8'h41, 3'd0, 1'b1, 1'b1);   // R1 no carry
        do_op(8'hFF, 8'h55, 3'd1, 1'b1, 1'b1);   // R2 wrap
        do_op(8'h7F, 8'h00, 3'd1, 1'b1, 1'b1);   // R2 sign
        do_op(8'hF0, 8'h3C, 3'd2, 1'b1, 1'b1);   // R3
        do_op(8'hF0, 8'h0C, 3'd3, 1'b1, 1'b1);   // R3
        do_op(8'hAA, 8'hAA, 3'd4, 1'b1, 1'b1);   // R3 zero
        do_op(8'hFF, 8'h12, 3'd5, 1'b1, 1'b1);   // R4 zero
        do_op(8'h0F, 8'hFF, 3'd5, 1'b1, 1'b1);   // R4 C ignored
        do_op(8'h81, 8'h00, 3'd6, 1'b1, 1'b1);   // R5
        do_op(8'h80, 8'h00, 3'd6, 1'b1, 1'b1);   // R5 wrap
        do_op(8'hFF, 8'hFF, 3'd7, 1'b1, 1'b1);   // R6
        do_op(8'hFF, 8'h01, 3'd0, 1'b1, 1'b1);   // set carry
        do_op(8'h12, 8'h34, 3'd3, 1'b0, 1'b0);   // R9 gated, R10 hold
        do_op(8'h80, 8'h01, 3'd2, 1'b1, 1'b0);   // R10 hold

        for (int i = 0; i < 400; i++) begin
            do_op(8'($urandom), 8'($urandom), 3'($urandom),
                  ($urandom % 4) != 0, ($urandom % 2) == 0);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule